// File: doc/BRIEF.md
# Memory-Mapped GPIO Bank with Atomic Set/Clear

A general-purpose I/O bank for a parameterized number of pins, reached over a small register bus whose transfer is a window of one or more consecutive bytes. Each pin has a 2-bit mode field that selects how it is driven: input only, push-pull from the output register, open-drain from the output register, or driven by a per-pin alternate source. Pin levels are brought in through a flip-flop synchronizer chain and can be read as an input register.

Besides plain writes to the output register, software can change single output bits without a read-modify-write. It writes a 2-bit code per pin into a write-only set/clear register: one code sets the bit, another clears it, and the two others leave it alone. Because a bus transfer can span several bytes, one write can touch the output register and the set/clear register together. In that case the set/clear codes take precedence for their pins.

With the default 8 pins the byte map is: mode at 0x00 (low byte, pins 0 to 3) and 0x01 (pins 4 to 7), input at 0x02, output at 0x03, set/clear at 0x04 (pins 0 to 3) and 0x05 (pins 4 to 7). All other offsets are unmapped.

Top module: `gpio_bank`

## Requirements
- R1: After a synchronous active-low reset, all mode fields and all output bits are 0 and the synchronizer stages hold 0. Reading bytes 0x00 to 0x03 returns 0 and no pin output enable is asserted.
- R2: The mode register is read/write at bytes 0x00 and 0x01 as one 16-bit value. Pin i's field sits at bits 2i+1:2i of that value, so byte 0x00 holds pins 0 to 3.
- R3: Bit i of byte 0x02 reads pin_in[i] as it was sampled SYNC_STAGES rising clock edges earlier (2 by default). A level change is invisible after one edge and visible after the second.
- R4: The output register is read/write at byte 0x03, with bit i belonging to pin i. Neither register changes in a cycle without a strobed write.
- R5: The set/clear register spans bytes 0x04 and 0x05. Pin i's field is bits 2i+1:2i of that 16-bit value. Code 01 sets output bit i, code 10 clears it, and codes 00 and 11 leave it unchanged.
- R6: Reads of bytes 0x04 and 0x05 return 0. Bytes 0x06 and above read 0, and writes to them change no register.
- R7: The pin drive depends on the mode. For 00, pin_oe=0 and pin_out=0. For 01, pin_oe=1 and pin_out=output bit. For 10, pin_out=0 and pin_oe=NOT output bit. For 11, pin_out=alt_out and pin_oe=alt_oe.
- R8: When one transfer writes byte 0x03 and a set/clear byte together, a set/clear code 01 or 10 overrides the written output value for its pin. Codes 00 and 11 keep the written value. Set/clear bytes whose lane is not strobed have no effect.
- R9: Lane k of a transfer (data bits 8k+7:8k, strobe bus_be[k]) addresses byte bus_addr+k for both reads and writes. Only strobed lanes are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Byte offset of lane 0 |
| bus_we | input | 1 | Write request this cycle |
| bus_be | input | LANES | Per-lane write strobe |
| bus_wdata | input | 8*LANES | Write data, lane k in bits 8k+7:8k |
| bus_rdata | output | 8*LANES | Combinational read data for the addressed window |
| pin_in | input | NPINS | Raw pin levels, asynchronous |
| alt_out | input | NPINS | Alternate drive value per pin |
| alt_oe | input | NPINS | Alternate output enable per pin |
| pin_out | output | NPINS | Value driven toward each pin |
| pin_oe | output | NPINS | Output enable toward each pin |

## Verification
A plain write of the output register and a set/clear operation can both land on one output bit in the same cycle. This happens when a two-lane write starts at byte 0x03, so lane 1 falls on the first set/clear byte. The bench provokes this directly with mixed codes and also skews its random writes toward that address. It judges the outcome against a bench model that applies the plain write first and the set/clear codes second. It also repeats such a write with the set/clear lane unstrobed, to confirm that the codes are then dropped.

// File: rtl/gpio_bank_pkg.sv
// Shared constants and byte-map arithmetic for the GPIO bank.
// Assumes: registers are packed in the order mode, input, output, set/clear,
// each rounded up to whole bytes.
package gpio_bank_pkg;

    typedef enum logic [1:0] {
        PM_INPUT     = 2'b00,
        PM_PUSHPULL  = 2'b01,
        PM_OPENDRAIN = 2'b10,
        PM_ALT       = 2'b11
    } pin_mode_e;

    localparam logic [1:0] SC_SET   = 2'b01;
    localparam logic [1:0] SC_CLEAR = 2'b10;

    function automatic int mode_bytes(input int n);
        return (2 * n + 7) / 8;
    endfunction

    function automatic int bit_bytes(input int n);
        return (n + 7) / 8;
    endfunction

    function automatic int in_offset(input int n);
        return mode_bytes(n);
    endfunction

    function automatic int out_offset(input int n);
        return mode_bytes(n) + bit_bytes(n);
    endfunction

    function automatic int sc_offset(input int n);
        return out_offset(n) + bit_bytes(n);
    endfunction

    function automatic int map_end(input int n);
        return sc_offset(n) + mode_bytes(n);
    endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
// Multi-stage synchronizer for the raw pin levels.
// Assumes: STAGES >= 1; all stages clear to 0 on reset.
module gpio_bank_sync #(
    parameter int NPINS  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] raw_in,
    output logic [NPINS-1:0] sync_out
);

    logic [NPINS-1:0] stage_q [STAGES];

    // Shift the pin levels down the chain one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= raw_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_bank_regs.sv
// Register file and byte decoder of the GPIO bank.
// Holds the mode and output registers. It applies plain writes first and
// set/clear codes second, so set/clear wins on a shared bit. It returns
// read data for every lane of the addressed window.
// Assumes: the bus window is LANES consecutive bytes starting at bus_addr.
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int LANES  = 2,
    parameter int ADDR_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [LANES-1:0]     bus_be,
    input  logic [8*LANES-1:0]   bus_wdata,
    output logic [8*LANES-1:0]   bus_rdata,
    input  logic [NPINS-1:0]     in_sync,
    output logic [2*NPINS-1:0]   mode_q,
    output logic [NPINS-1:0]     out_q
);

    localparam int MB      = mode_bytes(NPINS);
    localparam int BB      = bit_bytes(NPINS);
    localparam int IN_OFF  = in_offset(NPINS);
    localparam int OUT_OFF = out_offset(NPINS);
    localparam int SC_OFF  = sc_offset(NPINS);
    localparam int LAW     = ADDR_W + 1;

    logic [8*MB-1:0] mode_pad, mode_nx;
    logic [8*BB-1:0] out_pad, out_nx, in_pad;
    logic [LAW-1:0]  lane_addr [LANES];

    assign mode_pad = {{(8*MB-2*NPINS){1'b0}}, mode_q};
    assign out_pad  = {{(8*BB-NPINS){1'b0}}, out_q};
    assign in_pad   = {{(8*BB-NPINS){1'b0}}, in_sync};

    // Byte address seen by each lane of the window.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_addr[k] = {1'b0, bus_addr} + LAW'(k);
    end

    // Next register values: plain writes, then set/clear codes on top.
    always_comb begin
        mode_nx = mode_pad;
        out_nx  = out_pad;
        for (int k = 0; k < LANES; k++) begin
            if (bus_we && bus_be[k]) begin
                for (int b = 0; b < MB; b++)
                    if (int'(lane_addr[k]) == b) mode_nx[b*8 +: 8] = bus_wdata[k*8 +: 8];
                for (int b = 0; b < BB; b++)
                    if (int'(lane_addr[k]) == OUT_OFF + b) out_nx[b*8 +: 8] = bus_wdata[k*8 +: 8];
            end
        end
        for (int k = 0; k < LANES; k++) begin
            if (bus_we && bus_be[k]) begin
                for (int b = 0; b < MB; b++) begin
                    if (int'(lane_addr[k]) == SC_OFF + b) begin
                        for (int f = 0; f < 4; f++) begin
                            if (bus_wdata[k*8 + 2*f +: 2] == SC_SET)   out_nx[b*4 + f] = 1'b1;
                            if (bus_wdata[k*8 + 2*f +: 2] == SC_CLEAR) out_nx[b*4 + f] = 1'b0;
                        end
                    end
                end
            end
        end
    end

    // Register update with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            out_q  <= '0;
        end else begin
            mode_q <= mode_nx[2*NPINS-1:0];
            out_q  <= out_nx[NPINS-1:0];
        end
    end

    // Read mux: each lane returns its byte, or zero for write-only or unmapped.
    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < LANES; k++) begin
            for (int b = 0; b < MB; b++)
                if (int'(lane_addr[k]) == b) bus_rdata[k*8 +: 8] = mode_pad[b*8 +: 8];
            for (int b = 0; b < BB; b++) begin
                if (int'(lane_addr[k]) == IN_OFF + b)  bus_rdata[k*8 +: 8] = in_pad[b*8 +: 8];
                if (int'(lane_addr[k]) == OUT_OFF + b) bus_rdata[k*8 +: 8] = out_pad[b*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/gpio_bank_padmux.sv
// Per-pin drive selection from the mode field.
// Assumes: mode encodings as in gpio_bank_pkg::pin_mode_e.
module gpio_bank_padmux
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic [2*NPINS-1:0] mode_q,
    input  logic [NPINS-1:0]   out_q,
    input  logic [NPINS-1:0]   alt_out,
    input  logic [NPINS-1:0]   alt_oe,
    output logic [NPINS-1:0]   pin_out,
    output logic [NPINS-1:0]   pin_oe
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pin_mode_e mode;
        assign mode = pin_mode_e'(mode_q[2*i +: 2]);

        // Choose value and enable for this pin.
        always_comb begin
            unique case (mode)
                PM_INPUT:     begin pin_out[i] = 1'b0;       pin_oe[i] = 1'b0;      end
                PM_PUSHPULL:  begin pin_out[i] = out_q[i];   pin_oe[i] = 1'b1;      end
                PM_OPENDRAIN: begin pin_out[i] = 1'b0;       pin_oe[i] = ~out_q[i]; end
                default:      begin pin_out[i] = alt_out[i]; pin_oe[i] = alt_oe[i]; end
            endcase
        end
    end

endmodule

// File: rtl/gpio_bank.sv
// GPIO bank top: synchronizer, register file and pin drive mux.
// Assumes: single clock domain; pin_in is asynchronous to clk.
module gpio_bank #(
    parameter int NPINS       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int LANES       = 2,
    parameter int ADDR_W      = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [LANES-1:0]   bus_be,
    input  logic [8*LANES-1:0] bus_wdata,
    output logic [8*LANES-1:0] bus_rdata,
    input  logic [NPINS-1:0]   pin_in,
    input  logic [NPINS-1:0]   alt_out,
    input  logic [NPINS-1:0]   alt_oe,
    output logic [NPINS-1:0]   pin_out,
    output logic [NPINS-1:0]   pin_oe
);

    logic [NPINS-1:0]   in_sync;
    logic [2*NPINS-1:0] mode_q;
    logic [NPINS-1:0]   out_q;

    gpio_bank_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_in(pin_in), .sync_out(in_sync)
    );

    gpio_bank_regs #(.NPINS(NPINS), .LANES(LANES), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .in_sync(in_sync), .mode_q(mode_q), .out_q(out_q)
    );

    gpio_bank_padmux #(.NPINS(NPINS)) u_pad (
        .mode_q(mode_q), .out_q(out_q), .alt_out(alt_out), .alt_oe(alt_oe),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

endmodule

// File: rtl/gpio_bank_chk.sv
// Assertion checker for gpio_bank, attached by bind below.
// Assumes: reset is held low from time zero for at least one clock edge.
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int LANES  = 2,
    parameter int ADDR_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_we,
    input logic [LANES-1:0]   bus_be,
    input logic [8*LANES-1:0] bus_rdata,
    input logic [NPINS-1:0]   alt_out,
    input logic [NPINS-1:0]   alt_oe,
    input logic [NPINS-1:0]   pin_out,
    input logic [NPINS-1:0]   pin_oe,
    input logic [2*NPINS-1:0] mode_q,
    input logic [NPINS-1:0]   out_q
);

    localparam int END_OFF = map_end(NPINS);

    // R1: a reset cycle leaves mode and output cleared
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (mode_q == '0 && out_q == '0));

    // R4: no strobed write, no register change
    assert_hold_nowrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we || bus_be == '0) |=> ($stable(out_q) && $stable(mode_q)));

    // R6: a window starting past the map reads zero
    assert_unmapped_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bus_addr) >= END_OFF) |-> (bus_rdata == '0));

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        // R7: input-only pins are not driven
        assert_mode_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[2*i +: 2] == 2'b00) |-> (!pin_oe[i] && !pin_out[i]));
        // R7: push-pull follows the output bit
        assert_mode_pushpull_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[2*i +: 2] == 2'b01) |-> (pin_oe[i] && pin_out[i] == out_q[i]));
        // R7: open-drain only pulls low
        assert_mode_opendrain_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[2*i +: 2] == 2'b10) |-> (!pin_out[i] && pin_oe[i] == !out_q[i]));
        // R7: alternate mode passes the alternate source
        assert_mode_alt_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[2*i +: 2] == 2'b11) |-> (pin_oe[i] == alt_oe[i] && pin_out[i] == alt_out[i]));
    end

endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS), .LANES(LANES), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_be(bus_be),
    .bus_rdata(bus_rdata), .alt_out(alt_out), .alt_oe(alt_oe), .pin_out(pin_out),
    .pin_oe(pin_oe), .mode_q(mode_q), .out_q(out_q)
);

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  pin_in = '0, alt_out = '0, alt_oe = '0;
    logic [7:0]  pin_out, pin_oe;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [15:0] m_mode = '0;
    logic [7:0]  m_out = '0;
    logic [7:0]  m_in = '0;

    gpio_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .alt_out(alt_out),
        .alt_oe(alt_oe), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model of a write: plain bytes first, then set/clear codes (R5, R8, R9).
    function automatic void model_write(input int a, input logic [1:0] be, input logic [15:0] d);
        for (int k = 0; k < 2; k++) begin
            if (be[k]) begin
                case (a + k)
                    0: m_mode[7:0]  = d[k*8 +: 8];
                    1: m_mode[15:8] = d[k*8 +: 8];
                    3: m_out        = d[k*8 +: 8];
                    default: ;
                endcase
            end
        end
        for (int k = 0; k < 2; k++) begin
            if (be[k] && (a + k == 4 || a + k == 5)) begin
                for (int f = 0; f < 4; f++) begin
                    int p = (a + k - 4) * 4 + f;
                    if (d[k*8 + 2*f +: 2] == 2'b01) m_out[p] = 1'b1;
                    if (d[k*8 + 2*f +: 2] == 2'b10) m_out[p] = 1'b0;
                end
            end
        end
    endfunction

    function automatic logic [7:0] exp_byte(input int a);
        case (a)
            0: return m_mode[7:0];
            1: return m_mode[15:8];
            2: return m_in;
            3: return m_out;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [15:0] exp_drive();
        logic [7:0] o, oe;
        for (int i = 0; i < 8; i++) begin
            case (m_mode[2*i +: 2])
                2'b00: begin o[i] = 1'b0;       oe[i] = 1'b0;       end
                2'b01: begin o[i] = m_out[i];   oe[i] = 1'b1;       end
                2'b10: begin o[i] = 1'b0;       oe[i] = ~m_out[i];  end
                default: begin o[i] = alt_out[i]; oe[i] = alt_oe[i]; end
            endcase
        end
        return {oe, o};
    endfunction

    task automatic wr(input logic [2:0] a, input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_be = '0;
        model_write(int'(a), be, d);
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic check_window(input string req, input logic [2:0] a);
        logic [15:0] v;
        rd(a, v);
        check(req, {16'h0, v}, {16'h0, exp_byte(int'(a) + 1), exp_byte(int'(a))});
    endtask

    task automatic check_pins(input string req);
        #1 check(req, {16'h0, pin_oe, pin_out}, {16'h0, exp_drive()});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'h1357_2468));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        rd(3'd0, v); check("R1 mode", {16'h0, v}, 32'h0);
        rd(3'd2, v); check("R1 in/out", {16'h0, v}, 32'h0);
        check("R1 oe", {24'h0, pin_oe}, 32'h0);

        // R2, R9: mode readback and field position (pin 0 push-pull)
        wr(3'd3, 2'b01, 16'h0001);
        wr(3'd0, 2'b11, 16'h0001);
        check_window("R2 mode", 3'd0);
        check("R2 pin0 drive", {30'h0, pin_oe[0], pin_out[0]}, 32'h3);
        wr(3'd1, 2'b01, 16'h00C0);
        check_window("R9 lane0 at addr1", 3'd0);

        // R3: synchronizer latency
        @(negedge clk) pin_in = 8'hA5;
        rd(3'd2, v); check("R3 after one edge", {24'h0, v[7:0]}, 32'h00);
        rd(3'd2, v); check("R3 after two edges", {24'h0, v[7:0]}, 32'hA5);
        m_in = 8'hA5;

        // R4, R5: output write, then set/clear with every code
        wr(3'd3, 2'b01, 16'h005A);
        check_window("R4 output", 3'd2);
        wr(3'd4, 2'b11, 16'h1BC9);
        check_window("R5 set/clear", 3'd2);
        check("R5 fixed value", {24'h0, m_out}, 32'h59);

        // R6: set/clear reads zero, unmapped reads and writes
        rd(3'd4, v); check("R6 sc read", {16'h0, v}, 32'h0);
        wr(3'd6, 2'b11, 16'hFFFF);
        rd(3'd6, v); check("R6 unmapped read", {16'h0, v}, 32'h0);
        rd(3'd7, v); check("R6 past end", {16'h0, v}, 32'h0);
        check_window("R6 regs kept", 3'd0);
        check_window("R6 regs kept", 3'd2);

        // R8: output write and set/clear in one transfer
        wr(3'd3, 2'b11, 16'h39FF);
        check_window("R8 collision", 3'd2);
        check("R8 fixed value", {24'h0, m_out}, 32'hFD);
        wr(3'd3, 2'b11, 16'h0100);
        check("R8 set over zero", {24'h0, m_out}, 32'h01);
        check_window("R8 set over zero", 3'd2);
        wr(3'd3, 2'b01, 16'h5500);
        check_window("R8 unstrobed sc lane", 3'd2);

        // R7: every mode on some pin
        alt_out = 8'hC3; alt_oe = 8'h96;
        wr(3'd0, 2'b11, 16'hE4E4);
        wr(3'd3, 2'b01, 16'h00AA);
        check_pins("R7 mixed modes");
        wr(3'd3, 2'b01, 16'h0055);
        check_pins("R7 mixed modes flipped");

        // Random mix, skewed toward the collision window
        for (int n = 0; n < 300; n++) begin
            logic [2:0] a;
            a = ($urandom % 4 == 0) ? 3'd3 : 3'($urandom);
            @(negedge clk) pin_in = 8'($urandom);
            alt_out = 8'($urandom); alt_oe = 8'($urandom);
            wr(a, 2'($urandom), 16'($urandom));
            m_in = pin_in;
            check_window("R9 random mode", 3'd0);
            check_window("R8 random in/out", 3'd2);
            check_window("R6 random sc", 3'd4);
            check_pins("R7 random drive");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule